// File: doc/BRIEF.md
# TDM Slot Serializer with Per-Channel Offsets

This block is the transmit side of a stereo audio port that shares one serial data line with other devices on a time-division-multiplexed bus using DSP-style framing. A frame begins when the frame-sync (word clock) input is seen rising on a bit-clock rising tick. From that point the block counts bit clocks. It sends a first sample word, then a second one, MSB first, with data changing on bit-clock falling ticks so that a receiver can sample on the rising ticks. Outside its own two slots the block leaves the line undriven. Several instances, each programmed with different offsets, can therefore interleave their channels on one wire.

The first slot starts a programmable number of bit clocks after the frame sync. The second slot starts a separate programmable number of bit clocks after the last bit of the first slot. The block also supports a selectable word length, per-channel enables, swapping of the two channels between the slots, and an early release of the line. Sample words and all configuration are latched at the frame sync. The bit clock is given as two single-cycle strobes in the system clock domain, one for the rising edge and one for the falling edge.

Operation is split over three state machines. The frame sequencer has the states ST_IDLE, ST_LEAD, ST_FIRST, ST_GAP, ST_SECOND and ST_DONE:
- A frame sync moves it from any state to ST_LEAD, or straight to ST_FIRST when the first offset is zero.
- On each falling tick it moves ST_LEAD→ST_FIRST when the lead count runs out.
- ST_FIRST→ST_GAP follows the last first-slot bit, or ST_FIRST→ST_SECOND when the second offset is zero.
- ST_GAP→ST_SECOND follows when the gap count runs out.
- ST_SECOND→ST_DONE follows the last second-slot bit.

The line driver has the states LN_FLOAT, LN_DRIVE and LN_TAIL:
- On each falling tick it enters LN_DRIVE for an enabled data bit, LN_TAIL for the final bit of a slot, and LN_FLOAT otherwise.
- LN_TAIL→LN_FLOAT also occurs on a rising tick in early-release mode.
- A frame sync forces LN_FLOAT.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, and until the first frame sync, `sdout_oe` is 0.
- R2: A frame starts on a rising tick where `fsync` is 1 after being 0 at the previous rising tick. With a first offset of zero, the MSB of the first slot is driven on the very next falling tick. Bits change only on falling ticks, MSB first, and are taken from the top of the left-justified sample word.
- R3: The first slot begins `cfg_off1` bit clocks after the frame sync (0 to 255).
- R4: The second slot begins `cfg_off2` bit clocks (0 to 255) after the last bit of the first slot.
- R5: `sdout_oe` is 0 during offset bit clocks and after the second slot. Bit clocks beyond the end of the second slot leave the line idle until the next frame sync.
- R6: With `cfg_early_hiz`=1, `sdout_oe` drops on the rising tick that follows the last bit of a slot. With it at 0, `sdout_oe` holds until the next falling tick.
- R7: With `cfg_swap`=0 the first slot carries `left_data` and the second carries `right_data`. With `cfg_swap`=1 the order is reversed.
- R8: `cfg_left_en`/`cfg_right_en` gate each channel wherever it is placed. The slot of a disabled channel keeps `sdout_oe` at 0, and the other slot is unaffected.
- R9: `cfg_wlen` selects the slot length: 0 gives 16 bits, 1 gives 20 bits, 2 gives 24 bits and 3 gives 32 bits.
- R10: Samples and configuration are captured at the frame sync. Changes made later in the frame have no effect until the next frame.
- R11: A frame sync that arrives during a slot ends the transmission in progress. `sdout_oe` is 0 after that rising tick, and counting restarts from the new sync.
- R12: When the frame length equals offsets plus two words, frames run back to back and the second frame is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_rise | input | 1 | Single-cycle strobe marking a bit-clock rising edge |
| bclk_fall | input | 1 | Single-cycle strobe marking a bit-clock falling edge |
| fsync | input | 1 | Frame sync (word clock), sampled on rising ticks |
| left_data | input | SAMPLE_W | Left sample, left-justified |
| right_data | input | SAMPLE_W | Right sample, left-justified |
| cfg_wlen | input | 2 | Word length code |
| cfg_off1 | input | OFF_W | First-slot offset from the frame sync |
| cfg_off2 | input | OFF_W | Second-slot offset from the end of the first slot |
| cfg_left_en | input | 1 | Left channel enable |
| cfg_right_en | input | 1 | Right channel enable |
| cfg_swap | input | 1 | Send right first, then left |
| cfg_early_hiz | input | 1 | Release the line half a bit early after a slot |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for the data pad (1 = drive) |

## Verification
The bench builds the block with its defaults: SAMPLE_W=32 and OFF_W=8. These values let it reach a first offset of 255, full 32-bit slots, and an exact 66-bit back-to-back frame with one offset bit per slot. Small word lengths, together with zero and nonzero offsets, reach both adjacent and separated slots. This in turn exercises the half-bit early release between adjacent slots.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_FIRST,
        ST_GAP,
        ST_SECOND,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        LN_FLOAT,
        LN_DRIVE,
        LN_TAIL
    } line_state_e;

    // index of the last bit of a slot for each word length code
    function automatic logic [5:0] wlen_last(input logic [1:0] code);
        unique case (code)
            2'd0:    wlen_last = 6'd15;
            2'd1:    wlen_last = 6'd19;
            2'd2:    wlen_last = 6'd23;
            default: wlen_last = 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
    import tdm_tx_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             fsync,
    input  logic [1:0]       cfg_wlen,
    input  logic [OFF_W-1:0] cfg_off1,
    input  logic [OFF_W-1:0] cfg_off2,
    input  logic             cfg_left_en,
    input  logic             cfg_right_en,
    input  logic             cfg_swap,
    input  logic             cfg_early_hiz,
    output logic             frame_start,
    output logic             bit_drive,
    output logic             bit_slot,
    output logic             bit_last,
    output logic             slot_en,
    output logic             early_mode
);

    localparam int CNT_W = (OFF_W > 6) ? OFF_W : 6;

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] wl_last_q;
    logic [OFF_W-1:0] off2_q;
    logic             en_first_q, en_second_q, early_q;
    logic             fsync_q;

    assign frame_start = bclk_rise && fsync && !fsync_q;
    assign early_mode  = early_q;

    // state register and frame-time captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            wl_last_q   <= '0;
            off2_q      <= '0;
            en_first_q  <= 1'b0;
            en_second_q <= 1'b0;
            early_q     <= 1'b0;
            fsync_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (bclk_rise) fsync_q <= fsync;
            if (frame_start) begin
                wl_last_q   <= CNT_W'(wlen_last(cfg_wlen));
                off2_q      <= cfg_off2;
                en_first_q  <= cfg_swap ? cfg_right_en : cfg_left_en;
                en_second_q <= cfg_swap ? cfg_left_en  : cfg_right_en;
                early_q     <= cfg_early_hiz;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_start) begin
            if (cfg_off1 == '0) begin
                state_d = ST_FIRST;
                cnt_d   = CNT_W'(wlen_last(cfg_wlen));
            end else begin
                state_d = ST_LEAD;
                cnt_d   = CNT_W'(cfg_off1) - 1'b1;
            end
        end else if (bclk_fall) begin
            unique case (state_q)
                ST_IDLE, ST_DONE: ;
                ST_LEAD: begin
                    if (cnt_q == '0) begin
                        state_d = ST_FIRST;
                        cnt_d   = wl_last_q;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_FIRST: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (off2_q == '0) begin
                        state_d = ST_SECOND;
                        cnt_d   = wl_last_q;
                    end else begin
                        state_d = ST_GAP;
                        cnt_d   = CNT_W'(off2_q) - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) begin
                        state_d = ST_SECOND;
                        cnt_d   = wl_last_q;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_SECOND: begin
                    if (cnt_q == '0) state_d = ST_DONE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // per-tick outputs
    always_comb begin
        bit_drive = 1'b0;
        bit_slot  = 1'b0;
        bit_last  = 1'b0;
        slot_en   = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                bit_drive = bclk_fall;
                bit_last  = (cnt_q == '0);
                slot_en   = en_first_q;
            end
            ST_SECOND: begin
                bit_drive = bclk_fall;
                bit_slot  = 1'b1;
                bit_last  = (cnt_q == '0);
                slot_en   = en_second_q;
            end
            default: ;
        endcase
    end

    AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall)); // R2

    AST_SLOT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST || state_q == ST_SECOND) |-> (cnt_q <= wl_last_q)); // R9

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state_q == ST_LEAD || state_q == ST_FIRST)); // R11

endmodule

// File: rtl/tdm_shift_out.sv
module tdm_shift_out #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                cfg_swap,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic [SAMPLE_W-1:0] right_data,
    input  logic                bit_drive,
    input  logic                bit_slot,
    output logic                tx_bit
);

    localparam int NSLOT = 2;

    logic [NSLOT-1:0] msb;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [SAMPLE_W-1:0] sh_q;
        logic [SAMPLE_W-1:0] load_word;

        assign load_word = ((g == 0) ^ cfg_swap) ? left_data : right_data;
        assign msb[g]    = sh_q[SAMPLE_W-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (frame_start) begin
                sh_q <= load_word;
            end else if (bit_drive && (bit_slot == g[0])) begin
                sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign tx_bit = msb[bit_slot];

endmodule

// File: rtl/tdm_line_drv.sv
module tdm_line_drv
    import tdm_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic frame_start,
    input  logic bit_drive,
    input  logic bit_last,
    input  logic slot_en,
    input  logic early_mode,
    input  logic tx_bit,
    output logic sdout,
    output logic sdout_oe
);

    line_state_e ln_q, ln_d;
    logic        sd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= LN_FLOAT;
            sd_q <= 1'b0;
        end else begin
            ln_q <= ln_d;
            if (bclk_fall) sd_q <= (bit_drive && slot_en) ? tx_bit : 1'b0;
        end
    end

    // next state
    always_comb begin
        ln_d = ln_q;
        if (frame_start) begin
            ln_d = LN_FLOAT;
        end else if (bclk_fall) begin
            if (bit_drive && slot_en) ln_d = bit_last ? LN_TAIL : LN_DRIVE;
            else                      ln_d = LN_FLOAT;
        end else if (bclk_rise && early_mode && ln_q == LN_TAIL) begin
            ln_d = LN_FLOAT;
        end
    end

    // outputs
    always_comb begin
        unique case (ln_q)
            LN_DRIVE, LN_TAIL: sdout_oe = 1'b1;
            default:           sdout_oe = 1'b0;
        endcase
        sdout = sdout_oe && sd_q;
    end

    AST_SYNC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !sdout_oe); // R11

    AST_OE_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdout_oe) |-> $past(bclk_fall)); // R2

    AST_OE_NEEDS_ENABLED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdout_oe) |-> $past(bit_drive && slot_en)); // R8

    AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && !frame_start && !early_mode) |=> $stable(sdout_oe)); // R6

    AST_DATA_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sd_q)); // R2

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int OFF_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic                fsync,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic [SAMPLE_W-1:0] right_data,
    input  logic [1:0]          cfg_wlen,
    input  logic [OFF_W-1:0]    cfg_off1,
    input  logic [OFF_W-1:0]    cfg_off2,
    input  logic                cfg_left_en,
    input  logic                cfg_right_en,
    input  logic                cfg_swap,
    input  logic                cfg_early_hiz,
    output logic                sdout,
    output logic                sdout_oe
);

    logic frame_start, bit_drive, bit_slot, bit_last, slot_en, early_mode, tx_bit;

    tdm_frame_ctl #(.OFF_W(OFF_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_rise    (bclk_rise),
        .bclk_fall    (bclk_fall),
        .fsync        (fsync),
        .cfg_wlen     (cfg_wlen),
        .cfg_off1     (cfg_off1),
        .cfg_off2     (cfg_off2),
        .cfg_left_en  (cfg_left_en),
        .cfg_right_en (cfg_right_en),
        .cfg_swap     (cfg_swap),
        .cfg_early_hiz(cfg_early_hiz),
        .frame_start  (frame_start),
        .bit_drive    (bit_drive),
        .bit_slot     (bit_slot),
        .bit_last     (bit_last),
        .slot_en      (slot_en),
        .early_mode   (early_mode)
    );

    tdm_shift_out #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cfg_swap   (cfg_swap),
        .left_data  (left_data),
        .right_data (right_data),
        .bit_drive  (bit_drive),
        .bit_slot   (bit_slot),
        .tx_bit     (tx_bit)
    );

    tdm_line_drv u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .frame_start(frame_start),
        .bit_drive  (bit_drive),
        .bit_last   (bit_last),
        .slot_en    (slot_en),
        .early_mode (early_mode),
        .tx_bit     (tx_bit),
        .sdout      (sdout),
        .sdout_oe   (sdout_oe)
    );

    AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (u_ctl.state_q == ST_IDLE) |-> !sdout_oe); // R1

endmodule

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0, fsync = 1'b0;
    logic [31:0] left_data = '0, right_data = '0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic [7:0]  cfg_off1 = '0, cfg_off2 = '0;
    logic        cfg_left_en = 1'b1, cfg_right_en = 1'b1, cfg_swap = 1'b0, cfg_early_hiz = 1'b0;
    logic        sdout, sdout_oe;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct {
        logic  oe;
        logic  d;
        logic  chk_d;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    tdm_slot_tx i_tdm_slot_tx (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fsync(fsync), .left_data(left_data), .right_data(right_data),
        .cfg_wlen(cfg_wlen), .cfg_off1(cfg_off1), .cfg_off2(cfg_off2),
        .cfg_left_en(cfg_left_en), .cfg_right_en(cfg_right_en),
        .cfg_swap(cfg_swap), .cfg_early_hiz(cfg_early_hiz),
        .sdout(sdout), .sdout_oe(sdout_oe)
    );

    // monitor: one expected item per bit-clock tick
    initial begin
        forever begin
            @(posedge clk);
            if (bclk_rise || bclk_fall) begin
                @(negedge clk);
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R5 unexpected tick: oe=%b expected nothing queued", sdout_oe);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (sdout_oe !== e.oe || (e.chk_d && sdout !== e.d)) begin
                        bad++;
                        $display("FAIL %s oe=%b exp %b, d=%b exp %b", e.tag, sdout_oe, e.oe, sdout, e.d);
                    end
                end
            end
        end
    end

    task automatic bit_period(input logic fs);
        @(negedge clk); fsync = fs; bclk_rise = 1'b1;
        @(negedge clk); bclk_rise = 1'b0; fsync = 1'b0;
        @(negedge clk); bclk_fall = 1'b1;
        @(negedge clk); bclk_fall = 1'b0;
    endtask

    task automatic idle_periods(input int n, input string tag);
        for (int p = 0; p < 2 * n; p++) begin
            exp_t e;
            e.oe = 1'b0; e.d = 1'b0; e.chk_d = 1'b0; e.tag = tag;
            exp_q.push_back(e);
        end
        for (int p = 0; p < n; p++) bit_period(1'b0);
    endtask

    // driver: predicts a frame from the requirements, then plays it
    task automatic send_frame(input int nper, input string tag, input bit scramble);
        int          w, o1, o2, s2;
        logic [31:0] wd [2];
        logic        en [2];
        logic        er, prev_oe, prev_last;
        w  = (cfg_wlen == 2'd0) ? 16 : (cfg_wlen == 2'd1) ? 20 : (cfg_wlen == 2'd2) ? 24 : 32;
        o1 = cfg_off1;
        o2 = cfg_off2;
        s2 = o1 + w + o2;
        wd[0] = cfg_swap ? right_data : left_data;
        wd[1] = cfg_swap ? left_data : right_data;
        en[0] = cfg_swap ? cfg_right_en : cfg_left_en;
        en[1] = cfg_swap ? cfg_left_en : cfg_right_en;
        er = cfg_early_hiz;
        prev_oe = 1'b0; prev_last = 1'b0;
        for (int p = 0; p < nper; p++) begin
            exp_t r, f;
            int   sl, idx;
            r.oe = (p == 0) ? 1'b0 : (prev_oe && !(er && prev_last));
            r.d = 1'b0; r.chk_d = 1'b0; r.tag = tag;
            exp_q.push_back(r);
            sl = -1; idx = 0;
            if (p >= o1 && p < o1 + w) begin sl = 0; idx = p - o1; end
            else if (p >= s2 && p < s2 + w) begin sl = 1; idx = p - s2; end
            f.oe    = (sl >= 0) ? en[sl] : 1'b0;
            f.d     = (sl >= 0) ? wd[sl][31 - idx] : 1'b0;
            f.chk_d = f.oe;
            f.tag   = tag;
            exp_q.push_back(f);
            prev_oe   = f.oe;
            prev_last = (sl >= 0) && (idx == w - 1);
        end
        for (int p = 0; p < nper; p++) begin
            bit_period(p == 0);
            if (scramble && p == 2) begin
                left_data = ~left_data; right_data = ~right_data;
                cfg_wlen = ~cfg_wlen; cfg_off1 = cfg_off1 + 8'd5; cfg_off2 = cfg_off2 + 8'd3;
                cfg_swap = ~cfg_swap; cfg_left_en = ~cfg_left_en; cfg_early_hiz = ~cfg_early_hiz;
            end
        end
    endtask

    task automatic setup(input logic [1:0] wl, input logic [7:0] a, input logic [7:0] b,
                         input logic le, input logic re, input logic sw, input logic ea);
        cfg_wlen = wl; cfg_off1 = a; cfg_off2 = b;
        cfg_left_en = le; cfg_right_en = re; cfg_swap = sw; cfg_early_hiz = ea;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (sdout_oe !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset oe=%b expected 0", sdout_oe);
        end
        idle_periods(4, "R1");

        left_data = 32'hA5C3_1E77; right_data = 32'h3C96_E0F1;
        setup(2'd3, 8'd0, 8'd0, 1, 1, 0, 0);
        send_frame(68, "R2", 0);

        setup(2'd0, 8'd1, 8'd1, 1, 1, 0, 0);
        send_frame(40, "R4", 0);

        left_data = 32'h8001_7FFE; right_data = 32'hF00F_5AA5;
        setup(2'd2, 8'd255, 8'd3, 1, 1, 0, 0);
        send_frame(310, "R3", 0);

        setup(2'd1, 8'd2, 8'd4, 1, 1, 0, 0);
        send_frame(60, "R9", 0);

        setup(2'd1, 8'd0, 8'd2, 1, 1, 1, 0);
        send_frame(50, "R7", 0);

        setup(2'd0, 8'd3, 8'd1, 0, 1, 0, 0);
        send_frame(40, "R8", 0);
        setup(2'd0, 8'd3, 8'd1, 1, 0, 1, 0);
        send_frame(40, "R8", 0);

        setup(2'd0, 8'd1, 8'd0, 1, 1, 0, 1);
        send_frame(40, "R6", 0);
        setup(2'd0, 8'd1, 8'd2, 1, 1, 0, 1);
        send_frame(40, "R6", 0);
        setup(2'd0, 8'd1, 8'd0, 1, 1, 0, 0);
        send_frame(40, "R6", 0);

        left_data = 32'h1234_5678; right_data = 32'hCAFE_0BAD;
        setup(2'd0, 8'd2, 8'd1, 1, 1, 0, 0);
        send_frame(45, "R10", 1);

        left_data = 32'hFFFF_0000; right_data = 32'h0F0F_F0F0;
        setup(2'd0, 8'd2, 8'd1, 1, 1, 0, 0);
        send_frame(10, "R11", 0);
        send_frame(40, "R11", 0);

        setup(2'd2, 8'd4, 8'd2, 1, 1, 0, 0);
        send_frame(80, "R5", 0);

        left_data = 32'hDEAD_BEEF; right_data = 32'h0123_4567;
        setup(2'd3, 8'd1, 8'd1, 1, 1, 0, 0);
        send_frame(66, "R12", 0);
        left_data = 32'h7654_3210; right_data = 32'hFEDC_BA98;
        send_frame(66, "R12", 0);
        send_frame(4, "R12", 0);

        repeat (8) @(negedge clk);
        if (exp_q.size() != 0) begin
            bad++;
            total++;
            $display("FAIL R5 %0d expected ticks never observed, expected 0 left", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule